// File: doc/BRIEF.md
# PCI Target Data-Phase Handshake Controller

This block is the target side of a simplified PCI bus transaction. When the bus is idle and the master raises the frame signal, it captures the address and command nibble. It checks the address against a window given by a base value and a don't-care mask, and it claims the transaction by driving the device-select output. It then works through the data phases. A phase completes only on a clock where the initiator-ready input and the target-ready output are both high. A local ready input lets the attached register file insert wait states.

For each completed phase the block emits a one-cycle strobe to the local side, together with a direction flag and the index of the phase within the transaction. The transaction ends in one of two ways:

- The master has already dropped frame when a phase completes.
- The target reaches its own limit on consecutive phases. It then raises stop together with target-ready, which disconnects the master with that phase's data.

After the last phase the block waits until frame and initiator-ready are both low, then accepts a new address phase. All bus signals here are active-high logic levels. The pad inversion and tri-state control sit outside this block.

Top module: `pci_tgt_hs`

## Requirements
- R1: While reset is held and on the first clock after its release, tgt_devsel, tgt_trdy, tgt_stop and loc_strobe are low.
- R2: An address phase is the clock where bus_frame is sampled high with the target idle. If its command is memory read (4'b0110) or memory write (4'b0111), and the address matches win_base in every bit where win_mask is 0, then tgt_devsel is high from the second clock after the address phase until the final phase completes.
- R3: An address that differs from win_base in any bit where win_mask is 0 never raises tgt_devsel or tgt_trdy.
- R4: Any command code other than 4'b0110 and 4'b0111 is ignored: tgt_devsel stays low for that transaction.
- R5: While tgt_devsel is high, tgt_trdy equals loc_ready, so a low loc_ready inserts a wait state. Outside that window tgt_trdy is low.
- R6: loc_strobe is high on exactly those clocks where bus_irdy and tgt_trdy are both high, once per completed data phase.
- R7: While tgt_devsel is high, loc_write is 1 for a memory write and 0 for a memory read.
- R8: On each strobe, loc_index equals the number of phases already completed in the current transaction, starting at 0.
- R9: When a phase completes with bus_frame low, tgt_devsel, tgt_trdy and tgt_stop are all low on the next clock.
- R10: tgt_stop is high exactly when tgt_trdy is high and loc_index equals MAX_PHASES-1. A phase that completes with tgt_stop high ends the transaction even if bus_frame is still high, so at most MAX_PHASES phases complete.
- R11: After a transaction ends, the target returns to idle once bus_frame and bus_irdy are both sampled low. The next clock with bus_frame high is then a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_frame | input | 1 | Transaction in progress (high = asserted) |
| bus_irdy | input | 1 | Initiator ready |
| bus_ad | input | ADDR_W | Address, sampled in the address phase |
| bus_cmd | input | 4 | Command nibble, sampled in the address phase |
| win_base | input | ADDR_W | Base address of the claimed window |
| win_mask | input | ADDR_W | Address bits that are ignored in the match (1 = don't care) |
| loc_ready | input | 1 | Local side can complete a phase this clock |
| tgt_devsel | output | 1 | Target claims the transaction |
| tgt_trdy | output | 1 | Target ready |
| tgt_stop | output | 1 | Target requests disconnect |
| loc_strobe | output | 1 | One-cycle pulse per completed data phase |
| loc_write | output | 1 | Direction of the claimed transaction (1 = write) |
| loc_index | output | IDX_W | Phase number within the transaction |

## Verification
The hardest case to reach is the stop-driven disconnect, and in particular its coincidence with the master's own final phase. At that point tgt_stop, tgt_trdy and a falling bus_frame meet on the same clock, and a random wait state on either side can move the limit phase. The behavioural master therefore runs requests shorter than, equal to and longer than MAX_PHASES, with random waits on both bus_irdy and loc_ready. On every clock it predicts tgt_stop and the strobe from its own count of completed phases.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_TURN = 2'd3
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  // command nibble is one this target answers
  function automatic logic cmd_supported(input logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
  endfunction

  function automatic logic cmd_is_write(input logic [3:0] c);
    return c == CMD_MEM_WR;
  endfunction

endpackage

// File: rtl/tgt_decode.sv
module tgt_decode #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              cmd_ok,
  output logic              hit,
  output logic              is_write
);
  import pci_tgt_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cmd_q;

  // match on every bit not marked don't-care
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [ADDR_W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (capture) begin
      addr_q <= ad;
      cmd_q  <= cmd;
    end
  end

  assign cmd_ok   = cmd_supported(cmd);
  assign hit      = in_window(addr_q, base, mask) && cmd_supported(cmd_q);
  assign is_write = cmd_is_write(cmd_q);

endmodule

// File: rtl/tgt_phase_ctr.sv
module tgt_phase_ctr #(
  parameter int MAX_PHASES = 4,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] count,
  output logic             at_limit
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_PHASES - 1);

  logic [IDX_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (step)  count_q <= count_q + 1'b1;
  end

  assign count    = count_q;
  assign at_limit = (count_q == LIMIT);

endmodule

// File: rtl/tgt_fsm.sv
module tgt_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic irdy,
  input  logic loc_ready,
  input  logic hit,
  input  logic at_limit,
  output logic addr_phase,
  output logic devsel,
  output logic trdy,
  output logic stop,
  output logic xfer
);
  import pci_tgt_pkg::*;

  tgt_state_e state_q, state_d;
  logic       last_phase;

  assign addr_phase = (state_q == ST_IDLE) && frame;
  assign devsel     = (state_q == ST_DATA);
  assign trdy       = devsel && loc_ready;
  assign stop       = trdy && at_limit;
  assign xfer       = trdy && irdy;
  assign last_phase = xfer && (!frame || stop);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (frame)          state_d = ST_ADDR;
      ST_ADDR: state_d = hit ? ST_DATA : ST_TURN;
      ST_DATA: if (last_phase)     state_d = ST_TURN;
      ST_TURN: if (!frame && !irdy) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pci_tgt_hs.sv
module pci_tgt_hs #(
  parameter int  ADDR_W     = 32,
  parameter int  MAX_PHASES = 4,
  localparam int IDX_W      = $clog2(MAX_PHASES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_frame,
  input  logic              bus_irdy,
  input  logic [ADDR_W-1:0] bus_ad,
  input  logic [3:0]        bus_cmd,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic              loc_ready,
  output logic              tgt_devsel,
  output logic              tgt_trdy,
  output logic              tgt_stop,
  output logic              loc_strobe,
  output logic              loc_write,
  output logic [IDX_W-1:0]  loc_index
);

  logic addr_phase;
  logic cmd_ok;
  logic hit;
  logic wr_q;
  logic at_limit;
  logic xfer;

  tgt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (addr_phase),
    .ad       (bus_ad),
    .cmd      (bus_cmd),
    .base     (win_base),
    .mask     (win_mask),
    .cmd_ok   (cmd_ok),
    .hit      (hit),
    .is_write (wr_q)
  );

  tgt_phase_ctr #(.MAX_PHASES(MAX_PHASES), .IDX_W(IDX_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (addr_phase),
    .step     (xfer),
    .count    (loc_index),
    .at_limit (at_limit)
  );

  tgt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame      (bus_frame),
    .irdy       (bus_irdy),
    .loc_ready  (loc_ready),
    .hit        (hit),
    .at_limit   (at_limit),
    .addr_phase (addr_phase),
    .devsel     (tgt_devsel),
    .trdy       (tgt_trdy),
    .stop       (tgt_stop),
    .xfer       (xfer)
  );

  assign loc_strobe = xfer;
  assign loc_write  = tgt_devsel && wr_q;

endmodule

// File: rtl/pci_tgt_hs_chk.sv
module pci_tgt_hs_chk #(
  parameter int MAX_PHASES = 4,
  parameter int IDX_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame,
  input logic             irdy,
  input logic             loc_ready,
  input logic             devsel,
  input logic             trdy,
  input logic             stop,
  input logic             strobe,
  input logic [IDX_W-1:0] index,
  input logic             addr_phase,
  input logic             cmd_ok
);
  localparam logic [IDX_W-1:0] MAXV = IDX_W'(MAX_PHASES);

  assert_devsel_after_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel) |-> $past(addr_phase, 2));

  assert_bad_cmd_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && !cmd_ok |-> ##2 !devsel);

  assert_trdy_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trdy |-> devsel && loc_ready);

  assert_strobe_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> irdy && trdy);

  assert_index_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    index <= MAXV);

  assert_final_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !frame |=> !devsel && !trdy && !stop);

  assert_stop_with_trdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> trdy);

endmodule

bind pci_tgt_hs pci_tgt_hs_chk #(.MAX_PHASES(MAX_PHASES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame      (bus_frame),
  .irdy       (bus_irdy),
  .loc_ready  (loc_ready),
  .devsel     (tgt_devsel),
  .trdy       (tgt_trdy),
  .stop       (tgt_stop),
  .strobe     (loc_strobe),
  .index      (loc_index),
  .addr_phase (addr_phase),
  .cmd_ok     (cmd_ok)
);

// File: tb/tb_pci_tgt_hs.sv
module tb_pci_tgt_hs;
  localparam int ADDR_W = 32;
  localparam int MAXP   = 4;
  localparam int IDX_W  = $clog2(MAXP + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_frame, bus_irdy, loc_ready;
  logic [ADDR_W-1:0] bus_ad, win_base, win_mask;
  logic [3:0]        bus_cmd;
  logic              tgt_devsel, tgt_trdy, tgt_stop, loc_strobe, loc_write;
  logic [IDX_W-1:0]  loc_index;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  pci_tgt_hs #(.ADDR_W(ADDR_W), .MAX_PHASES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_frame(bus_frame), .bus_irdy(bus_irdy),
    .bus_ad(bus_ad), .bus_cmd(bus_cmd), .win_base(win_base), .win_mask(win_mask),
    .loc_ready(loc_ready), .tgt_devsel(tgt_devsel), .tgt_trdy(tgt_trdy),
    .tgt_stop(tgt_stop), .loc_strobe(loc_strobe), .loc_write(loc_write),
    .loc_index(loc_index)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    @(negedge clk);
    bus_frame = 0; bus_irdy = 0; bus_ad = '0; bus_cmd = 4'h0; loc_ready = 1;
  endtask

  // behavioural master; hit transaction requesting nreq phases
  task automatic run_txn(input logic [31:0] addr, input logic [3:0] cmd, input int nreq,
                         input int irdy_wait, input int rdy_wait);
    int  done = 0;
    bit  ended = 0;
    bit  stopped = 0;
    int  guard = 0;
    bit  nxt;
    bit  xf;
    bit  is_wr = (cmd == 4'b0111);
    @(negedge clk);
    bus_frame = 1; bus_irdy = 0; bus_ad = addr; bus_cmd = cmd;
    #1 chk("R2 devsel low in address phase", tgt_devsel, 0);
    @(negedge clk);
    bus_ad = '0; bus_cmd = 4'h0;
    #1 chk("R2 devsel low in decode clock", tgt_devsel, 0);
    while (!ended && guard < 400) begin
      guard++;
      @(negedge clk);
      if (bus_frame) begin
        nxt = ($urandom_range(99) >= irdy_wait);
        if (nxt && (nreq - done) == 1) bus_frame = 0;
        bus_irdy = nxt;
      end
      loc_ready = ($urandom_range(99) >= rdy_wait);
      #1;
      chk("R2 devsel held in data", tgt_devsel, 1);
      chk("R5 trdy follows loc_ready", tgt_trdy, loc_ready);
      chk("R10 stop at limit", tgt_stop, (loc_ready && done == MAXP - 1));
      chk("R7 direction", loc_write, is_wr);
      xf = bus_irdy && loc_ready;
      chk("R6 strobe on handshake", loc_strobe, xf);
      if (xf) begin
        chk("R8 phase index", loc_index, done);
        done++;
        if (!bus_frame || tgt_stop) begin
          ended = 1;
          stopped = tgt_stop;
        end
      end
    end
    bus_idle();
    #1;
    chk("R9 devsel released", tgt_devsel, 0);
    chk("R9 trdy released", tgt_trdy, 0);
    chk("R9 stop released", tgt_stop, 0);
    chk("R10 completed phases", done, (nreq < MAXP) ? nreq : MAXP);
    chk("R10 ended by stop", stopped, (nreq >= MAXP));
  endtask

  // non-claimed transaction: master waits, then aborts
  task automatic run_ignored(input logic [31:0] addr, input logic [3:0] cmd, input string req);
    @(negedge clk);
    bus_frame = 1; bus_irdy = 0; bus_ad = addr; bus_cmd = cmd;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bus_irdy = 1; bus_ad = '0;
      #1;
      chk({req, " devsel stays low"}, tgt_devsel, 0);
      chk({req, " trdy stays low"}, tgt_trdy, 0);
      chk({req, " no strobe"}, loc_strobe, 0);
    end
    bus_idle();
    bus_idle();
  endtask

  task automatic t_reset();   // R1
    rst_n = 0;
    bus_frame = 0; bus_irdy = 0; bus_ad = '0; bus_cmd = 4'h0; loc_ready = 1;
    win_base = 32'h0000_1000; win_mask = 32'h0000_00FF;
    repeat (3) @(negedge clk);
    #1 chk("R1 devsel in reset", tgt_devsel, 0);
    chk("R1 trdy in reset", tgt_trdy, 0);
    rst_n = 1;
    @(negedge clk);
    #1 chk("R1 stop after reset", tgt_stop, 0);
    chk("R1 strobe after reset", loc_strobe, 0);
  endtask

  task automatic t_single_read();  run_txn(32'h0000_1004, 4'b0110, 1, 0, 0);   endtask
  task automatic t_write_burst();  run_txn(32'h0000_10F0, 4'b0111, 3, 30, 30); endtask
  task automatic t_stop_limit();   run_txn(32'h0000_1000, 4'b0110, 7, 20, 20); endtask
  task automatic t_exact_limit();  run_txn(32'h0000_1080, 4'b0111, MAXP, 25, 25); endtask
  task automatic t_miss_addr();    run_ignored(32'h0000_2004, 4'b0110, "R3"); endtask
  task automatic t_bad_cmd();      run_ignored(32'h0000_1010, 4'b1010, "R4"); endtask

  task automatic t_back_to_back();  // R11: new address accepted right after idle
    run_ignored(32'h0001_1000, 4'b0111, "R3");
    run_txn(32'h0000_1020, 4'b0111, 2, 0, 0);
    run_txn(32'h0000_1024, 4'b0110, 2, 0, 0);
    chk("R11 sequence completed", 1, 1);
  endtask

  task automatic t_random_waits();  // R5 heavy waits
    for (int k = 0; k < 25; k++)
      run_txn(32'h0000_1000 | 32'($urandom_range(255)),
              ($urandom_range(1) != 0) ? 4'b0111 : 4'b0110,
              1 + int'($urandom_range(6)), 60, 60);
  endtask

  initial begin
    t_reset();
    t_single_read();
    t_write_burst();
    t_stop_limit();
    t_exact_limit();
    t_miss_addr();
    t_bad_cmd();
    t_back_to_back();
    t_random_waits();
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule